// File: doc/BRIEF.md
# RV32I Integer Execution Unit

This block is the purely combinational integer datapath of a small 32-bit core. Given an operation code, a first operand taken from a source register and a second operand that is either another source register or the raw immediate field of an instruction, it returns one 32-bit result. This happens in the same cycle: no clock or storage sits inside. It covers addition, subtraction, signed and unsigned set-less-than, the three bitwise logic operations, and the three shifts. It also covers placing a 20-bit constant into the upper bits of a word.

When the immediate flag is set, the block takes the low 12 bits of the second operand and sign-extends them to 32 bits. The result is then used in place of the register value. Comparisons produce 0 or 1 as ordinary data. Sums wrap silently, and the block keeps no carry, overflow or other flag. Register shift amounts use only their low five bits. Instruction decoding, the register file and multiply/divide belong to other blocks.

Top module: `rv_int_alu`

## Requirements
- R1: Operation code 0 (add) outputs A + B modulo 2^32, so 0xFFFFFFFF + 1 gives 0, with no indication of the wrap.
- R2: Operation code 1 (subtract) outputs A − opnd_b modulo 2^32, always using the full register operand, whether or not use_imm is set.
- R3: With use_imm high, every operation except subtract and upper-load uses bits [11:0] of opnd_b, sign-extended from bit 11, as operand B; bits [31:12] of opnd_b have no effect.
- R4: Operation code 2 (signed set-less-than) outputs 1 when A < B as two's-complement numbers and 0 otherwise, including 0 for equal operands.
- R5: Operation code 3 (unsigned set-less-than) outputs 1 when A < B as unsigned numbers and 0 otherwise; with use_imm, an immediate field of 0xFFF compares as 0xFFFFFFFF.
- R6: Operation codes 4, 5 and 6 output the bitwise XOR, OR and AND of A and B respectively.
- R7: Operation code 7 (left shift) shifts A left by B[4:0], filling with zeros; upper bits of B are ignored, so a shift by 33 equals a shift by 1.
- R8: Operation code 8 (logical right shift) shifts A right by B[4:0] and fills the vacated upper bits with zeros.
- R9: Operation code 9 (arithmetic right shift) shifts A right by B[4:0] and fills the vacated upper bits with A[31].
- R10: Operation code 10 (upper load) outputs opnd_b[19:0] placed in bits [31:12] with bits [11:0] zero; opnd_a, use_imm and opnd_b[31:20] have no effect.
- R11: Operation codes 11 to 15 output zero.
- R12: The result follows any change of the inputs within the same cycle, with no latency or retained state between operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code (0 add … 10 upper load; 11–15 unused) |
| opnd_a | input | 32 | First source operand |
| opnd_b | input | 32 | Second source register value or raw immediate field |
| use_imm | input | 1 | Selects the sign-extended 12-bit immediate as operand B |
| result | output | 32 | Operation result |

## Verification
The block holds no state, so any fault in its internal selection or shifting appears on `result` in the same cycle as the inputs that expose it. A wrong fill bit in the shared shifter shows up only for negative operands under arithmetic shifts, or as stray ones after logical shifts. A wrong sign-extension point shows up only for immediates with bit 11 set. A flipped comparator sign bit shows up only when the operands differ in sign. For this reason the stimulus pairs operands across the sign boundary, shift amounts of 0, 31, 32 and 33, and immediate fields with garbage upper bits. Each operation is applied back to back, so a result that leaks from one operation into the next is also caught.

// File: rtl/rv_alu_pkg.sv
package rv_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_SLT  = 4'd2,
    OP_SLTU = 4'd3,
    OP_XOR  = 4'd4,
    OP_OR   = 4'd5,
    OP_AND  = 4'd6,
    OP_SLL  = 4'd7,
    OP_SRL  = 4'd8,
    OP_SRA  = 4'd9,
    OP_LUI  = 4'd10
  } alu_op_e;

  typedef enum logic [1:0] {
    BW_XOR = 2'd0,
    BW_OR  = 2'd1,
    BW_AND = 2'd2
  } bitwise_e;
endpackage

// File: rtl/rv_alu_addsub.sv
module rv_alu_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         subtract,
  output logic [W-1:0] sum
);
  logic [W-1:0] b_eff;

  always_comb begin
    b_eff = subtract ? ~b : b;
    sum   = a + b_eff + {{(W-1){1'b0}}, subtract};
    // R2: a difference added back to the subtrahend restores the minuend
    if (subtract) begin
      p_sub_inverse_r2: assert (sum + b == a)
        else $error("subtract result does not invert");
    end
  end
endmodule

// File: rtl/rv_alu_compare.sv
module rv_alu_compare #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         unsigned_cmp,
  output logic [W-1:0] flag
);
  logic [W-1:0] a_key;
  logic [W-1:0] b_key;
  logic         less;

  always_comb begin
    // signed order equals unsigned order once the sign bits are inverted
    a_key = unsigned_cmp ? a : {~a[W-1], a[W-2:0]};
    b_key = unsigned_cmp ? b : {~b[W-1], b[W-2:0]};
    less  = a_key < b_key;
    flag  = {{(W-1){1'b0}}, less};
    // R4 / R5: equal operands are never less
    if (a == b) begin
      p_equal_not_less_r4: assert (flag == '0)
        else $error("equal operands reported less-than");
    end
  end
endmodule

// File: rtl/rv_alu_bitwise.sv
module rv_alu_bitwise #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]          a,
  input  logic [W-1:0]          b,
  input  rv_alu_pkg::bitwise_e  sel,
  output logic [W-1:0]          y
);
  import rv_alu_pkg::*;

  always_comb begin
    unique case (sel)
      BW_XOR:  y = a ^ b;
      BW_OR:   y = a | b;
      BW_AND:  y = a & b;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/rv_alu_shifter.sv
module rv_alu_shifter #(
  parameter int unsigned W  = 32,
  localparam int unsigned SW = $clog2(W)
) (
  input  logic [W-1:0]  a,
  input  logic [SW-1:0] shamt,
  input  logic          left,
  input  logic          arith,
  output logic [W-1:0]  y
);
  logic [W-1:0] rev_in;
  logic [W-1:0] rev_out;
  logic [W-1:0] src;
  logic [W-1:0] shifted;
  logic [W-1:0] fill_mask;
  logic         fill;

  // left shifts reuse the right shifter on a bit-reversed operand
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign rev_in[i]  = a[W-1-i];
    assign rev_out[i] = shifted[W-1-i];
  end

  always_comb begin
    src       = left ? rev_in : a;
    fill      = arith & ~left & a[W-1];
    fill_mask = ~({W{1'b1}} >> shamt);
    shifted   = (src >> shamt) | (fill_mask & {W{fill}});
  end

  always_comb begin
    y = left ? rev_out : shifted;
    // R9: arithmetic right shift keeps the sign
    if (arith && !left) begin
      p_sra_sign_r9: assert (y[W-1] == a[W-1])
        else $error("arithmetic shift lost sign");
    end
    // R8: logical right shift by a nonzero amount clears the top bit
    if (!arith && !left && shamt != '0) begin
      p_srl_zero_fill_r8: assert (y[W-1] == 1'b0)
        else $error("logical shift filled with one");
    end
  end
endmodule

// File: rtl/rv_int_alu.sv
module rv_int_alu #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned IMM_W  = 12,
  parameter int unsigned UIMM_W = 20,
  localparam int unsigned SHAMT_W   = $clog2(XLEN),
  localparam int unsigned LUI_SHIFT = XLEN - UIMM_W
) (
  input  logic [3:0]      op_sel,
  input  logic [XLEN-1:0] opnd_a,
  input  logic [XLEN-1:0] opnd_b,
  input  logic            use_imm,
  output logic [XLEN-1:0] result
);
  import rv_alu_pkg::*;

  alu_op_e        op;
  logic [XLEN-1:0] imm_sext;
  logic [XLEN-1:0] b_eff;
  logic [XLEN-1:0] b_arith;
  logic [XLEN-1:0] upper_val;
  logic [XLEN-1:0] arith_y;
  logic [XLEN-1:0] cmp_y;
  logic [XLEN-1:0] logic_y;
  logic [XLEN-1:0] shift_y;
  logic            is_sub;
  logic            is_left;
  logic            is_arith_sh;
  bitwise_e        bw_sel;

  always_comb begin
    op          = alu_op_e'(op_sel);
    imm_sext    = {{(XLEN-IMM_W){opnd_b[IMM_W-1]}}, opnd_b[IMM_W-1:0]};
    b_eff       = use_imm ? imm_sext : opnd_b;
    is_sub      = (op == OP_SUB);
    b_arith     = is_sub ? opnd_b : b_eff;
    is_left     = (op == OP_SLL);
    is_arith_sh = (op == OP_SRA);
    upper_val   = {opnd_b[UIMM_W-1:0], {LUI_SHIFT{1'b0}}};
    case (op)
      OP_OR:   bw_sel = BW_OR;
      OP_AND:  bw_sel = BW_AND;
      default: bw_sel = BW_XOR;
    endcase
  end

  rv_alu_addsub #(.W(XLEN)) u_addsub (
    .a        (opnd_a),
    .b        (b_arith),
    .subtract (is_sub),
    .sum      (arith_y)
  );

  rv_alu_compare #(.W(XLEN)) u_compare (
    .a            (opnd_a),
    .b            (b_eff),
    .unsigned_cmp (op == OP_SLTU),
    .flag         (cmp_y)
  );

  rv_alu_bitwise #(.W(XLEN)) u_bitwise (
    .a   (opnd_a),
    .b   (b_eff),
    .sel (bw_sel),
    .y   (logic_y)
  );

  rv_alu_shifter #(.W(XLEN)) u_shifter (
    .a     (opnd_a),
    .shamt (b_eff[SHAMT_W-1:0]),
    .left  (is_left),
    .arith (is_arith_sh),
    .y     (shift_y)
  );

  always_comb begin
    case (op)
      OP_ADD, OP_SUB:         result = arith_y;
      OP_SLT, OP_SLTU:        result = cmp_y;
      OP_XOR, OP_OR, OP_AND:  result = logic_y;
      OP_SLL, OP_SRL, OP_SRA: result = shift_y;
      OP_LUI:                 result = upper_val;
      default:                result = '0;
    endcase
    // R10: upper load leaves the low field clear
    if (op == OP_LUI) begin
      p_lui_low_zero_r10: assert (result[LUI_SHIFT-1:0] == '0)
        else $error("upper load low bits nonzero");
    end
  end
endmodule

// File: tb/rv_int_alu_tb.sv
module rv_int_alu_tb_top;
  localparam int unsigned WATCHDOG_CYCLES = 20000;

  typedef struct {
    logic [31:0] expected;
    string       tag;
  } exp_item_t;

  logic        clk;
  logic [3:0]  op_sel;
  logic [31:0] opnd_a;
  logic [31:0] opnd_b;
  logic        use_imm;
  logic [31:0] result;

  exp_item_t   sb_q[$];
  int          checks;
  int          errors;
  bit          finished;

  rv_int_alu dut_i (
    .op_sel  (op_sel),
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .use_imm (use_imm),
    .result  (result)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // reference model written from the requirement list
  function automatic logic [31:0] ref_model(input logic [3:0] op, input logic [31:0] a,
                                            input logic [31:0] b, input logic imm);
    logic [31:0] bv;
    logic [4:0]  sh;
    bv = imm ? {{20{b[11]}}, b[11:0]} : b;
    sh = bv[4:0];
    case (op)
      4'd0:  return a + bv;
      4'd1:  return a - b;
      4'd2:  return ($signed(a) < $signed(bv)) ? 32'd1 : 32'd0;
      4'd3:  return (a < bv) ? 32'd1 : 32'd0;
      4'd4:  return a ^ bv;
      4'd5:  return a | bv;
      4'd6:  return a & bv;
      4'd7:  return a << sh;
      4'd8:  return a >> sh;
      4'd9:  return $unsigned($signed(a) >>> sh);
      4'd10: return {b[19:0], 12'h000};
      default: return 32'd0;
    endcase
  endfunction

  // driver: applies inputs at the falling edge and queues the expectation
  task automatic drive(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic imm, input logic [31:0] exp, input string tag);
    exp_item_t it;
    @(negedge clk);
    op_sel  = op;
    opnd_a  = a;
    opnd_b  = b;
    use_imm = imm;
    it.expected = exp;
    it.tag      = tag;
    sb_q.push_back(it);
  endtask

  // monitor: compares half a cycle after each input change
  always @(posedge clk) begin
    if (sb_q.size() > 0) begin
      exp_item_t it;
      it = sb_q.pop_front();
      checks++;
      if (result !== it.expected) begin
        errors++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, result, it.expected);
      end
    end
  end

  initial begin
    checks = 0;
    errors = 0;
    finished = 1'b0;
    op_sel = 4'd15; opnd_a = '0; opnd_b = '0; use_imm = 1'b0;
    repeat (2) @(posedge clk);

    // R11: unused codes
    drive(4'd15, 32'hDEADBEEF, 32'h12345678, 1'b0, 32'h0, "R11 code 15");
    drive(4'd11, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 32'h0, "R11 code 11");
    // R1: add wrap
    drive(4'd0, 32'hFFFFFFFF, 32'h1, 1'b0, 32'h0, "R1 add wrap");
    drive(4'd0, 32'h7FFFFFFF, 32'h1, 1'b0, 32'h80000000, "R1 add signed overflow");
    // R3: immediate sign-extension, upper field ignored
    drive(4'd0, 32'h5, 32'hFFFFFFFF, 1'b1, 32'h4, "R3 addi -1");
    drive(4'd0, 32'h0, 32'hABCDE7FF, 1'b1, 32'h000007FF, "R3 imm max positive");
    drive(4'd0, 32'h0, 32'h00000800, 1'b1, 32'hFFFFF800, "R3 imm min negative");
    // R2: subtract
    drive(4'd1, 32'h3, 32'h5, 1'b0, 32'hFFFFFFFE, "R2 sub negative");
    drive(4'd1, 32'h5000, 32'h00001000, 1'b1, 32'h4000, "R2 sub ignores use_imm");
    // R4: signed compare
    drive(4'd2, 32'hFFFFFFFF, 32'h1, 1'b0, 32'h1, "R4 slt -1<1");
    drive(4'd2, 32'h1, 32'hFFFFFFFF, 1'b0, 32'h0, "R4 slt 1<-1");
    drive(4'd2, 32'h80000000, 32'h80000000, 1'b0, 32'h0, "R4 slt equal");
    drive(4'd2, 32'hFFFFFFFB, 32'h00000FFE, 1'b1, 32'h1, "R4 slti -5<-2");
    // R5: unsigned compare
    drive(4'd3, 32'h1, 32'hFFFFFFFF, 1'b0, 32'h1, "R5 sltu 1<max");
    drive(4'd3, 32'hFFFFFFFF, 32'h1, 1'b0, 32'h0, "R5 sltu max<1");
    drive(4'd3, 32'h7FFFFFFF, 32'h00000FFF, 1'b1, 32'h1, "R5 sltiu imm -1");
    drive(4'd3, 32'hFFFFFFFF, 32'h00000FFF, 1'b1, 32'h0, "R5 sltiu equal max");
    // R6: logic
    drive(4'd4, 32'hF0F0F0F0, 32'hFF00FF00, 1'b0, 32'h0FF00FF0, "R6 xor");
    drive(4'd5, 32'hF0F0F0F0, 32'h0F000F00, 1'b0, 32'hFFF0FFF0, "R6 or");
    drive(4'd6, 32'h12345678, 32'h00000FF0, 1'b1, 32'h12345670, "R6 andi negative imm");
    drive(4'd4, 32'h12345678, 32'h00000FFF, 1'b1, 32'hEDCBA987, "R6 xori -1 invert");
    // R7: left shift
    drive(4'd7, 32'h123, 32'd33, 1'b0, 32'h246, "R7 sll by 33 masked");
    drive(4'd7, 32'h1, 32'd31, 1'b1, 32'h80000000, "R7 slli 31");
    drive(4'd7, 32'hCAFEF00D, 32'd0, 1'b0, 32'hCAFEF00D, "R7 sll by 0");
    // R8: logical right
    drive(4'd8, 32'h80000000, 32'd31, 1'b0, 32'h1, "R8 srl 31");
    drive(4'd8, 32'h80000000, 32'd32, 1'b0, 32'h80000000, "R8 srl by 32 masked");
    drive(4'd8, 32'hFFFFFFFF, 32'd4, 1'b1, 32'h0FFFFFFF, "R8 srli zero fill");
    // R9: arithmetic right
    drive(4'd9, 32'h80000000, 32'd31, 1'b0, 32'hFFFFFFFF, "R9 sra 31");
    drive(4'd9, 32'h40000000, 32'd30, 1'b0, 32'h1, "R9 sra positive");
    drive(4'd9, 32'h80000010, 32'd4, 1'b1, 32'hF8000001, "R9 srai negative");
    // R10: upper load
    drive(4'd10, 32'h0, 32'h00012345, 1'b0, 32'h12345000, "R10 lui");
    drive(4'd10, 32'hDEADBEEF, 32'hFFFFFFFF, 1'b1, 32'hFFFFF000, "R10 lui ignores a and imm");

    // R12: back-to-back mixed operations, one per cycle
    begin
      logic [31:0] lfsr;
      lfsr = 32'hACE1_1234;
      for (int n = 0; n < 400; n++) begin
        logic [31:0] a;
        logic [31:0] b;
        logic [3:0]  op;
        logic        im;
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        a    = lfsr;
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        b    = (n % 5 == 0) ? {27'h0, lfsr[4:0]} : lfsr;
        op   = 4'(n % 16);
        im   = lfsr[7];
        drive(op, a, b, im, ref_model(op, a, b, im), "R12 back-to-back sweep");
      end
    end

    @(negedge clk);
    while (sb_q.size() > 0) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule